// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns up to sixteen external pin signals into interrupt requests. Every line has its own source multiplexer, which picks the same-numbered pin from one of several general-purpose ports. Before the multiplexer, each candidate pin passes through a two-flop synchronizer. The line then compares the selected, synchronized value with the value it held one cycle earlier. A rising or falling transition, when enabled for that line, sets a sticky pending flag. The line's IRQ output is high whenever its pending flag is set and its mask bit allows it.

Software sets up the block through a small register bus. A write takes effect at the clock edge on which `regWr` is high. A read is combinational from `regAddr`. An interrupt handler acknowledges an event by writing a one to the line's pending bit. If a new edge arrives in the same cycle as that acknowledge, the pending flag stays set, so the event is not lost. Rewriting a line's source selection never counts as an edge by itself.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. Every line selects port code 0.
- R2: The address map is: 0 mask, 1 rising enable, 2 falling enable, 3 pending, 4 to 7 source select. Bit n of the mask, enable and pending registers belongs to line n. Line n's 4-bit source code sits in select register 4 + n/4, at bits 4*(n%4)+3 down to 4*(n%4). Written values read back unchanged.
- R3: A source code p below NUM_PORTS routes `portPins[p*NUM_LINES + n]` to line n. For example, code 2 selects port C, the third port.
- R4: `irq[n]` is 1 exactly while pending bit n and mask bit n are both 1. A masked line still records its pending bit.
- R5: With only the rising enable set, a 0-to-1 transition sets the pending bit and a 1-to-0 transition does not.
- R6: With only the falling enable set, only 1-to-0 transitions set the pending bit. With both enables set, either transition sets it.
- R7: A pin change made between clock edges is visible in the pending bit after the third following rising clock edge, and not after the second.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: If a pending-clear write and a detected edge on the same line coincide in one cycle, the pending bit ends up set.
- R10: Changing a line's source code never sets its pending bit, even when the old and new sources differ in level.
- R11: A source code of NUM_PORTS or higher feeds the line a constant 0, so no pin activity can set its pending bit.
- R12: A line with neither edge enabled never sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| portPins | input | NUM_PORTS*NUM_LINES | Raw pins; port p, pin n at index p*NUM_LINES+n |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (3) | Register address |
| regWdata | input | DATA_W (16) | Write data |
| regRdata | output | DATA_W (16) | Combinational read data for regAddr |
| irq | output | NUM_LINES | Per-line interrupt request |

## Verification
The bench builds the block with its default values: sixteen lines and five implemented ports. This places all four select registers in use. It also leaves source codes 5 to 15 unimplemented, so codes 5 and 10 exercise the constant-low input. With five ports, port C at code 2 can be reached next to port A at code 0. This makes it possible to reselect between two pins held at different levels and to drive a set and an acknowledge into the same cycle.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int SEL_IDX_W = 4;

  typedef struct packed {
    logic                 wrMask;
    logic                 wrRise;
    logic                 wrFall;
    logic                 clrPend;
    logic                 wrSel;
    logic [SEL_IDX_W-1:0] selIdx;
  } strobe_t;
endpackage

// File: rtl/extint_ctl.sv
module extint_ctl #(
  parameter int ADDR_W    = 3,
  parameter int CTRL_REGS = 4
) (
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  output extint_pkg::strobe_t   stb
);
  localparam int IW = extint_pkg::SEL_IDX_W;

  always_comb begin
    stb         = '0;
    stb.wrMask  = regWr && (regAddr == ADDR_W'(0));
    stb.wrRise  = regWr && (regAddr == ADDR_W'(1));
    stb.wrFall  = regWr && (regAddr == ADDR_W'(2));
    stb.clrPend = regWr && (regAddr == ADDR_W'(3));
    stb.wrSel   = regWr && (regAddr >= ADDR_W'(CTRL_REGS));
    stb.selIdx  = IW'(regAddr - ADDR_W'(CTRL_REGS));
  end
endmodule

// File: rtl/extint_dp.sv
module extint_dp #(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 5,
  parameter int SEL_W     = 4,
  parameter int FPR       = 4,
  parameter int DATA_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  extint_pkg::strobe_t            stb,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_PORTS*NUM_LINES-1:0] portPins,
  output logic [NUM_LINES-1:0]           maskQ,
  output logic [NUM_LINES-1:0]           riseQ,
  output logic [NUM_LINES-1:0]           fallQ,
  output logic [NUM_LINES-1:0]           pendQ,
  output logic [NUM_LINES*SEL_W-1:0]     selQ,
  output logic [NUM_LINES-1:0]           setEv,
  output logic [NUM_LINES-1:0]           selChg
);
  localparam int NPINS = NUM_PORTS * NUM_LINES;
  localparam int IW    = extint_pkg::SEL_IDX_W;

  logic [NPINS-1:0] syncA, syncB;

  // two-stage synchronizer on every candidate pin, ahead of the muxes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= portPins;
      syncB <= syncA;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int REG = n / FPR;
    localparam int LSB = (n % FPR) * SEL_W;

    logic [SEL_W-1:0] curSel;
    logic [SEL_W-1:0] newSel;
    logic             selHit;
    logic             holdQ;
    logic             prevQ;
    logic             selPin;

    assign newSel = wdata[LSB +: SEL_W];
    assign selHit = stb.wrSel && (stb.selIdx == IW'(REG));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        curSel <= '0;
        holdQ  <= 1'b0;
        prevQ  <= 1'b0;
      end else begin
        if (selHit) curSel <= newSel;
        holdQ <= selHit && (newSel != curSel);
        prevQ <= selPin;
      end
    end

    always_comb begin
      selPin = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (curSel == SEL_W'(p)) selPin = syncB[p*NUM_LINES + n];
    end

    // the first cycle on a new source only reloads the edge history
    assign setEv[n]  = !holdQ && ((selPin && !prevQ && riseQ[n]) ||
                                  (!selPin && prevQ && fallQ[n]));
    assign selChg[n] = holdQ;
    assign selQ[n*SEL_W +: SEL_W] = curSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskQ <= '0;
      riseQ <= '0;
      fallQ <= '0;
      pendQ <= '0;
    end else begin
      if (stb.wrMask) maskQ <= wdata[NUM_LINES-1:0];
      if (stb.wrRise) riseQ <= wdata[NUM_LINES-1:0];
      if (stb.wrFall) fallQ <= wdata[NUM_LINES-1:0];
      pendQ <= (pendQ & ~(stb.clrPend ? wdata[NUM_LINES-1:0] : '0)) | setEv;
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter  int NUM_LINES = 16,
  parameter  int NUM_PORTS = 5,
  parameter  int SEL_W     = 4,
  localparam int FPR       = 4,
  localparam int CTRL_REGS = 4,
  localparam int SEL_REGS  = (NUM_LINES + FPR - 1) / FPR,
  localparam int ADDR_W    = $clog2(CTRL_REGS + SEL_REGS),
  localparam int SREG_W    = FPR * SEL_W,
  localparam int DATA_W    = (NUM_LINES > SREG_W) ? NUM_LINES : SREG_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*NUM_LINES-1:0] portPins,
  input  logic                           regWr,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [DATA_W-1:0]              regWdata,
  output logic [DATA_W-1:0]              regRdata,
  output logic [NUM_LINES-1:0]           irq
);
  localparam int SELBITS = SEL_REGS * SREG_W;

  extint_pkg::strobe_t        stb;
  logic [NUM_LINES-1:0]       maskQ, riseQ, fallQ, pendQ, setEv, selChg;
  logic [NUM_LINES*SEL_W-1:0] selQ;
  logic [SELBITS-1:0]         selPad;

  extint_ctl #(.ADDR_W(ADDR_W), .CTRL_REGS(CTRL_REGS)) u_ctl (
    .regWr(regWr), .regAddr(regAddr), .stb(stb)
  );

  extint_dp #(
    .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W),
    .FPR(FPR), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(regWdata),
    .portPins(portPins), .maskQ(maskQ), .riseQ(riseQ), .fallQ(fallQ),
    .pendQ(pendQ), .selQ(selQ), .setEv(setEv), .selChg(selChg)
  );

  assign selPad = SELBITS'(selQ);
  assign irq    = pendQ & maskQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(0): regRdata[NUM_LINES-1:0] = maskQ;
      ADDR_W'(1): regRdata[NUM_LINES-1:0] = riseQ;
      ADDR_W'(2): regRdata[NUM_LINES-1:0] = fallQ;
      ADDR_W'(3): regRdata[NUM_LINES-1:0] = pendQ;
      default: begin
        for (int k = 0; k < SEL_REGS; k++)
          if (regAddr == ADDR_W'(CTRL_REGS + k))
            regRdata[SREG_W-1:0] = selPad[k*SREG_W +: SREG_W];
      end
    endcase
  end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 regWr,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWdata,
  input logic [NUM_LINES-1:0] riseQ,
  input logic [NUM_LINES-1:0] fallQ,
  input logic [NUM_LINES-1:0] pendQ,
  input logic [NUM_LINES-1:0] setEv,
  input logic [NUM_LINES-1:0] selChg
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
    // R8: without a one written to its bit, a pending flag stays set
    a_r8_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pendQ[n] && !(regWr && regAddr == ADDR_W'(3) && regWdata[n])) |=> pendQ[n]);

    // R12: with no edge enabled, a clear flag stays clear
    a_r12_no_enable_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!pendQ[n] && !riseQ[n] && !fallQ[n]) |=> !pendQ[n]);

    // R9: a detected edge always leaves the flag set, even under a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      setEv[n] |=> pendQ[n]);

    // R10: the cycle after a source change cannot raise the flag
    a_r10_reselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (selChg[n] && !pendQ[n]) |=> !pendQ[n]);
  end
endmodule

bind extint_ctrl extint_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .riseQ(riseQ), .fallQ(fallQ), .pendQ(pendQ),
  .setEv(setEv), .selChg(selChg)
);

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
  localparam int NL = 16;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP*NL-1:0] pins = '0;
  logic          regWr = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [15:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic [NL-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  extint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .portPins(pins), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wrReg(input int a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'(a); regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input int a, output logic [15:0] v);
    regAddr = 3'(a);
    #1 v = regRdata;
  endtask

  task automatic setPin(input int p, input int n, input logic v);
    @(negedge clk);
    pins[p*NL + n] = v;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 8; a++) begin
      rdReg(a, v);
      check($sformatf("R1 reset reg %0d", a), 32'(v), 32'h0);
    end
    check("R1 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_regmap();
    logic [15:0] v;
    wrReg(1, 16'hFFFF); rdReg(1, v);
    check("R2 rise readback", 32'(v), 32'hFFFF);
    wrReg(1, 16'h0000);
    wrReg(7, 16'hA5C3); rdReg(7, v);
    check("R2 select reg 7 readback", 32'(v), 32'hA5C3);
    rdReg(6, v);
    check("R2 select reg 6 untouched", 32'(v), 32'h0);
    wrReg(7, 16'h0000);
  endtask

  task automatic t_select_rise();
    logic [15:0] v;
    wrReg(4, 16'h0200);           // line 2 -> code 2 (port C)
    wrReg(1, 16'h0004);
    wrReg(0, 16'h0004);
    setPin(0, 2, 1'b1);           // port A pin 2: not selected
    step(4); rdReg(3, v);
    check("R3 unselected port ignored", 32'(v[2]), 32'h0);
    setPin(2, 2, 1'b1);
    step(2); rdReg(3, v);
    check("R7 not visible after 2 edges", 32'(v[2]), 32'h0);
    step(1); rdReg(3, v);
    check("R7 R3 visible after 3 edges", 32'(v[2]), 32'h1);
    check("R4 irq on unmasked pending", 32'(irq[2]), 32'h1);
    wrReg(3, 16'h0004); rdReg(3, v);
    check("R8 write one clears", 32'(v[2]), 32'h0);
    check("R4 irq drops after clear", 32'(irq[2]), 32'h0);
    setPin(2, 2, 1'b0);
    step(4); rdReg(3, v);
    check("R5 falling ignored when rise only", 32'(v[2]), 32'h0);
    setPin(0, 2, 1'b0);
  endtask

  task automatic t_w0();
    logic [15:0] v;
    wrReg(1, 16'h0001);
    setPin(0, 0, 1'b1); step(4);
    wrReg(3, 16'h0000); rdReg(3, v);
    check("R8 write zero keeps pending", 32'(v[0]), 32'h1);
    wrReg(3, 16'hFFFE); rdReg(3, v);
    check("R8 other bits do not clear", 32'(v[0]), 32'h1);
    wrReg(3, 16'h0001); rdReg(3, v);
    check("R8 own bit clears", 32'(v[0]), 32'h0);
    setPin(0, 0, 1'b0);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wrReg(0, 16'h0000);
    wrReg(1, 16'h0020);
    setPin(0, 5, 1'b1); step(4); rdReg(3, v);
    check("R4 masked line still pending", 32'(v[5]), 32'h1);
    check("R4 masked line no irq", 32'(irq[5]), 32'h0);
    wrReg(0, 16'h0020);
    check("R4 unmask raises irq", 32'(irq[5]), 32'h1);
    wrReg(3, 16'h0020);
    setPin(0, 5, 1'b0);
  endtask

  task automatic t_both();
    logic [15:0] v;
    wrReg(1, 16'h0080); wrReg(2, 16'h0080);
    setPin(0, 7, 1'b1); step(4); rdReg(3, v);
    check("R6 both: rising sets", 32'(v[7]), 32'h1);
    wrReg(3, 16'h0080);
    setPin(0, 7, 1'b0); step(4); rdReg(3, v);
    check("R6 both: falling sets", 32'(v[7]), 32'h1);
    wrReg(3, 16'h0080);
    wrReg(1, 16'h0000); wrReg(2, 16'h0100);
    setPin(0, 8, 1'b1); step(4); rdReg(3, v);
    check("R6 fall only: rising ignored", 32'(v[8]), 32'h0);
    setPin(0, 8, 1'b0); step(4); rdReg(3, v);
    check("R6 fall only: falling sets", 32'(v[8]), 32'h1);
    wrReg(3, 16'h0100);
    wrReg(2, 16'h0000);
  endtask

  task automatic t_none();
    logic [15:0] v;
    wrReg(1, 16'h0000); wrReg(2, 16'h0000);
    setPin(0, 9, 1'b1); step(4);
    setPin(0, 9, 1'b0); step(4); rdReg(3, v);
    check("R12 no enable no pending", 32'(v[9]), 32'h0);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    wrReg(1, 16'h0002);
    setPin(0, 1, 1'b1);            // edges E1,E2 follow; set lands on E3
    @(negedge clk);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd3; regWdata = 16'h0002;
    @(negedge clk);
    regWr = 1'b0;
    rdReg(3, v);
    check("R9 set beats same-cycle clear", 32'(v[1]), 32'h1);
    wrReg(3, 16'h0002); rdReg(3, v);
    check("R9 later clear works", 32'(v[1]), 32'h0);
    setPin(0, 1, 1'b0);
  endtask

  task automatic t_reselect();
    logic [15:0] v;
    wrReg(1, 16'h0008);
    setPin(2, 3, 1'b1); step(4);   // port C pin 3 high, port A pin 3 low
    wrReg(4, 16'h2200);            // line 3 -> code 2, line 2 stays code 2
    step(5); rdReg(3, v);
    check("R10 reselect gives no edge", 32'(v[3]), 32'h0);
    rdReg(4, v);
    check("R2 line 3 field at bits 15:12", 32'(v), 32'h2200);
    setPin(2, 3, 1'b0); step(4);
    setPin(2, 3, 1'b1); step(4); rdReg(3, v);
    check("R10 R3 new source edges seen", 32'(v[3]), 32'h1);
    wrReg(3, 16'h0008);
    setPin(2, 3, 1'b0); step(4);
  endtask

  task automatic t_oor();
    logic [15:0] v;
    wrReg(7, 16'hA500);            // line 14 -> code 5, line 15 -> code 10
    wrReg(1, 16'hC000); wrReg(2, 16'hC000); wrReg(0, 16'hC000);
    for (int p = 0; p < NP; p++) begin
      pins[p*NL + 14] = 1'b1; pins[p*NL + 15] = 1'b1;
    end
    step(5); rdReg(3, v);
    check("R11 unimplemented code high pins", 32'(v[15:14]), 32'h0);
    for (int p = 0; p < NP; p++) begin
      pins[p*NL + 14] = 1'b0; pins[p*NL + 15] = 1'b0;
    end
    step(5); rdReg(3, v);
    check("R11 unimplemented code low pins", 32'(v[15:14]), 32'h0);
    check("R11 no irq", 32'(irq[15:14]), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_regmap();
    t_select_rise();
    t_w0();
    t_mask();
    t_both();
    t_none();
    t_setwins();
    t_reselect();
    t_oor();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule